// File: doc/BRIEF.md
# Burst Address Counter

This block supplies the word address for one port of a synchronous memory. On every rising clock edge it decides which address the current access uses. Four sources are possible: a forced zero, a freshly supplied external address, the address of the previous access plus one, or the previous address unchanged. Three active-low controls make the choice: a clear, an address strobe and a count enable. They are evaluated in a fixed order of precedence.

The chosen address is combinational. It is valid in the same cycle that the controls are applied. The same edge also stores it as the base for the next cycle. A burst of accesses can therefore start with one external load and then run from the counter alone, and neither a clear nor an increment costs an idle cycle. The block has no chip-select, byte-select or read/write inputs, so memory-side qualifiers have no effect on it. It holds no data storage and no output pipeline.

Top module: `burst_addr_ctr`

## Requirements
- R1: A synchronous reset (`rst` high on a rising edge) clears the stored address to 0. A hold cycle after reset presents address 0.
- R2: When `clearN` is 0, `curAddr` is 0 whatever the values of `strobeN`, `countEnN` and `extAddr`.
- R3: When `clearN` is 1 and `strobeN` is 0, `curAddr` equals `extAddr`. This holds even when `countEnN` is 0.
- R4: When `clearN`, `strobeN` and `countEnN` are all 1, `curAddr` equals the address used in the previous cycle, and `extAddr` has no effect.
- R5: When `clearN` and `strobeN` are 1 and `countEnN` is 0, `curAddr` equals the previous cycle's address plus one.
- R6: An increment from the highest address (all ones, 0x7FFF at the default 15-bit width) yields 0.
- R7: The address presented in a cycle is the base for the next cycle, with no idle cycle in between. An increment right after a clear gives 1, and successive increments give consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| extAddr | input | AddrW (15) | Externally supplied address |
| strobeN | input | 1 | Active-low load of `extAddr` |
| countEnN | input | 1 | Active-low increment of the previous address |
| clearN | input | 1 | Active-low force to address 0 |
| curAddr | output | AddrW (15) | Address used by the access in the current cycle |

## Verification
The bench goes after the precedence corners. One case drives a clear together with an active strobe and count enable. If the priority were wrong, this would yield `extAddr` or an incremented value instead of 0. Another case drives a load with count enable active. If increment were placed above load, the address would come out one past the stored base. A held cycle with a changing `extAddr` exposes a design that leaks the external bus through. An increment from 0x7FFF catches a counter that saturates or spills into a wider register. An increment straight after a clear catches a design that registers its choice and so adds a dead cycle: that design would show the stale address instead of 1.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Source selection produced by the control decoder, one-hot or all zero.
  typedef struct packed {
    logic clear;    // force address zero
    logic load;     // take the external address
    logic advance;  // previous address plus one
  } addrSel_t;

endpackage

// File: rtl/burst_addr_sel.sv
module burst_addr_sel
  import burst_addr_pkg::*;
(
  input  logic     strobeN,
  input  logic     countEnN,
  input  logic     clearN,
  output addrSel_t sel
);

  // Precedence: clear over load over advance; none of them means hold.
  always_comb begin
    sel         = '0;
    sel.clear   = ~clearN;
    sel.load    = clearN & ~strobeN;
    sel.advance = clearN & strobeN & ~countEnN;
  end

endmodule

// File: rtl/burst_addr_path.sv
module burst_addr_path
  import burst_addr_pkg::*;
#(
  parameter int AddrW = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  addrSel_t         sel,
  input  logic [AddrW-1:0] extAddr,
  output logic [AddrW-1:0] curAddr
);

  localparam logic [AddrW-1:0] StepOne = AddrW'(1);

  logic [AddrW-1:0] baseAddr;
  logic [AddrW-1:0] nextAddr;

  // Same-cycle address; the increment wraps naturally at the field width.
  always_comb begin
    if (sel.clear)        nextAddr = '0;
    else if (sel.load)    nextAddr = extAddr;
    else if (sel.advance) nextAddr = baseAddr + StepOne;
    else                  nextAddr = baseAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) baseAddr <= '0;
    else     baseAddr <= nextAddr;
  end

  assign curAddr = nextAddr;

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int AddrW = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AddrW-1:0] extAddr,
  input  logic             strobeN,
  input  logic             countEnN,
  input  logic             clearN,
  output logic [AddrW-1:0] curAddr
);

  addrSel_t sel;

  burst_addr_sel u_sel (
    .strobeN  (strobeN),
    .countEnN (countEnN),
    .clearN   (clearN),
    .sel      (sel)
  );

  burst_addr_path #(.AddrW(AddrW)) u_path (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .extAddr (extAddr),
    .curAddr (curAddr)
  );

endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int AddrW = 15
) (
  input logic             clk,
  input logic             rst,
  input logic [AddrW-1:0] extAddr,
  input logic             strobeN,
  input logic             countEnN,
  input logic             clearN,
  input logic [AddrW-1:0] curAddr
);

  localparam logic [AddrW-1:0] TopAddr = {AddrW{1'b1}};
  localparam logic [AddrW-1:0] StepOne = AddrW'(1);

  logic holdCyc;
  logic incCyc;
  assign holdCyc = clearN & strobeN & countEnN;
  assign incCyc  = clearN & strobeN & ~countEnN;

  // R1: hold directly after reset presents zero
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && holdCyc) |-> (curAddr == '0));

  // R2: clear dominates
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !clearN |-> (curAddr == '0));

  // R3: strobe loads the external address
  assert_load_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (clearN && !strobeN) |-> (curAddr == extAddr));

  // R4: hold repeats previous address
  assert_hold_prev_R4: assert property (@(posedge clk) disable iff (rst)
    (holdCyc && !$past(rst)) |-> (curAddr == $past(curAddr)));

  // R5: advance adds one to previous address
  assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (incCyc && !$past(rst)) |-> (curAddr == $past(curAddr) + StepOne));

  // R6: advance from the top wraps to zero
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (incCyc && !$past(rst) && $past(curAddr) == TopAddr) |-> (curAddr == '0));

endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.AddrW(AddrW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .extAddr  (extAddr),
  .strobeN  (strobeN),
  .countEnN (countEnN),
  .clearN   (clearN),
  .curAddr  (curAddr)
);

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;

  localparam int AddrW = 15;
  localparam int NumVec = 13;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [AddrW-1:0] extAddr = '0;
  logic             strobeN = 1'b1;
  logic             countEnN = 1'b1;
  logic             clearN = 1'b1;
  logic [AddrW-1:0] curAddr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  burst_addr_ctr #(.AddrW(AddrW)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .extAddr  (extAddr),
    .strobeN  (strobeN),
    .countEnN (countEnN),
    .clearN   (clearN),
    .curAddr  (curAddr)
  );

  // Vector: {req[3:0], clearN, strobeN, countEnN, extAddr[14:0], expected[14:0]}
  localparam logic [36:0] Vecs [NumVec] = '{
    {4'd4, 3'b111, 15'h1234, 15'h0000},  // R4 hold ignores extAddr
    {4'd3, 3'b101, 15'h0100, 15'h0100},  // R3 load
    {4'd5, 3'b110, 15'h7abc, 15'h0101},  // R5 advance
    {4'd7, 3'b110, 15'h0000, 15'h0102},  // R7 consecutive advance
    {4'd4, 3'b111, 15'h7777, 15'h0102},  // R4 hold
    {4'd3, 3'b100, 15'h2000, 15'h2000},  // R3 load beats advance
    {4'd2, 3'b000, 15'h3333, 15'h0000},  // R2 clear beats load and advance
    {4'd7, 3'b110, 15'h0000, 15'h0001},  // R7 advance right after clear
    {4'd3, 3'b101, 15'h7fff, 15'h7fff},  // R3 load top address
    {4'd6, 3'b110, 15'h0000, 15'h0000},  // R6 wrap to zero
    {4'd3, 3'b101, 15'h0055, 15'h0055},  // R3 load
    {4'd2, 3'b011, 15'h6666, 15'h0000},  // R2 clear with others idle
    {4'd4, 3'b111, 15'h1111, 15'h0000}   // R4 hold after clear
  };

  task automatic check(input string req, input logic [AddrW-1:0] exp);
    checks++;
    if (curAddr !== exp) begin
      fails++;
      $display("FAIL %s: curAddr=%h expected %h", req, curAddr, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic e,
                       input logic [AddrW-1:0] a);
    @(negedge clk);
    clearN = c; strobeN = s; countEnN = e; extAddr = a;
    #2;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, hold presents zero
    drive(1'b1, 1'b1, 1'b1, 15'h5a5a);
    check("R1", '0);

    for (int i = 0; i < NumVec; i++) begin
      drive(Vecs[i][32], Vecs[i][31], Vecs[i][30], Vecs[i][29:15]);
      check($sformatf("R%0d", Vecs[i][36:33]), Vecs[i][14:0]);
    end

    // R3 then R1: mid-run reset clears the stored base
    drive(1'b1, 1'b0, 1'b1, 15'h4444);
    check("R3", 15'h4444);
    @(negedge clk);
    rst = 1'b1; clearN = 1'b1; strobeN = 1'b1; countEnN = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 15'h4444);
    check("R1", '0);

    // R7 and R6: burst crossing the top of the space
    drive(1'b1, 1'b0, 1'b1, 15'h7ffe);
    check("R3", 15'h7ffe);
    drive(1'b1, 1'b1, 1'b0, 15'h0000);
    check("R7", 15'h7fff);
    drive(1'b1, 1'b1, 1'b0, 15'h0000);
    check("R6", 15'h0000);
    drive(1'b1, 1'b1, 1'b0, 15'h0000);
    check("R5", 15'h0001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule